// File: doc/BRIEF.md
# Multicycle Processor Step Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. Each instruction runs over several clock cycles. Every cycle, the block tells the shared datapath what to do: fetch the next instruction, read registers, compute an address or result, access memory, write back, or redirect the program counter. It is a Moore machine. A 4-bit step register holds the current step, and every control output depends only on that step. The 6-bit opcode from the instruction register is used only to choose the next step.

Every instruction begins with a fetch step and then a decode step. After decode, the block moves to a different sequence for each instruction class:

- Loads and stores go through an address step, then a memory read or write.
- Loads then take a write-back step.
- Register-to-register operations take an execute step and then a register write.
- Branch-if-equal takes one conditional step.
- Jump takes one step that loads the program counter.

Each sequence then returns to fetch. The datapath holds the opcode steady for the whole instruction.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the first cycle after it is released, the block is in the fetch step. In fetch, `pc_wr_en`, `mem_rd` and `ir_ld` are 1 and `alu_b_sel`=01. Every other output is 0.
- R2: The step after fetch is always decode. In decode, `alu_b_sel`=11 and every other output is 0.
- R3: Decode selects the next step from the opcode. 100011 (load) and 101011 (store) go to the address step. 000000 (register op) goes to execute. 000100 (branch-equal) goes to branch. 000010 (jump) goes to jump. Any other opcode goes back to fetch.
- R4: In the address step, `alu_a_sel`=1 and `alu_b_sel`=10, and every other output is 0. The next step is memory read if the opcode is load, and memory write otherwise.
- R5: In memory read, `mem_rd`=1 and `addr_sel`=1, and every other output is 0. The next step is write-back.
- R6: In write-back, `reg_wr`=1 and `wb_from_mem`=1, and every other output is 0. The next step is fetch.
- R7: In memory write, `mem_wr`=1 and `addr_sel`=1, and every other output is 0. The next step is fetch.
- R8: In execute, `alu_a_sel`=1 and `alu_ctl`=10, and every other output is 0. The next step is register write. In register write, `reg_wr`=1 and `dst_sel`=1, and every other output is 0. The next step is fetch.
- R9: In branch, `alu_a_sel`=1, `alu_ctl`=01, `pc_wr_cond`=1 and `pc_src`=01, and every other output is 0. The next step is fetch.
- R10: In jump, `pc_wr_en`=1 and `pc_src`=10, and every other output is 0. The next step is fetch.
- R11: `mem_rd` and `mem_wr` are never 1 in the same cycle. Any select not named for a step is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr_en | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the ALU reports equal |
| addr_sel | output | 1 | Memory address from the ALU output register (1) or the program counter (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from the memory data register (1) or the ALU output (0) |
| pc_src | output | 2 | Next program counter: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_ctl | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |
| alu_b_sel | output | 2 | ALU B operand: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A operand: register (1) or program counter (0) |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register from the rd field (1) or the rt field (0) |

## Verification
Some properties are checked on every cycle:

- Fetch is always followed by decode.
- A memory read with the data address is always followed by a write-back from memory.
- Any register write, memory write or conditional branch step returns to fetch on the next cycle.
- The two memory strobes never overlap.
- An unknown opcode in decode always leads back to fetch.

Only the bench scenarios can show that each step drives the exact full control word. The same holds for whether each opcode class follows its exact path through the steps, including load and store sharing the address step, and back-to-back instructions of different classes.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter logic [5:0] OP_ALU   = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BEQ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output logic       pc_wr_en,
  output logic       pc_wr_cond,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_ld,
  output logic       wb_from_mem,
  output logic [1:0] pc_src,
  output logic [1:0] alu_ctl,
  output logic [1:0] alu_b_sel,
  output logic       alu_a_sel,
  output logic       reg_wr,
  output logic       dst_sel
);

  typedef enum logic [3:0] {
    S_FETCH = 4'd0,
    S_DEC   = 4'd1,
    S_ADDR  = 4'd2,
    S_MRD   = 4'd3,
    S_WB    = 4'd4,
    S_MWR   = 4'd5,
    S_EXE   = 4'd6,
    S_RDONE = 4'd7,
    S_BR    = 4'd8,
    S_JUMP  = 4'd9
  } step_t;

  step_t cur, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur <= S_FETCH;
    else        cur <= nxt;

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = S_ADDR;
        else if (opcode == OP_ALU)                   nxt = S_EXE;
        else if (opcode == OP_BEQ)                   nxt = S_BR;
        else if (opcode == OP_JUMP)                  nxt = S_JUMP;
        else                                         nxt = S_FETCH;
      end
      S_ADDR:  nxt = (opcode == OP_LOAD) ? S_MRD : S_MWR;
      S_MRD:   nxt = S_WB;
      S_EXE:   nxt = S_RDONE;
      default: nxt = S_FETCH;
    endcase
  end

  assign pc_wr_en    = (cur == S_FETCH) || (cur == S_JUMP);
  assign pc_wr_cond  = (cur == S_BR);
  assign addr_sel    = (cur == S_MRD) || (cur == S_MWR);
  assign mem_rd      = (cur == S_FETCH) || (cur == S_MRD);
  assign mem_wr      = (cur == S_MWR);
  assign ir_ld       = (cur == S_FETCH);
  assign wb_from_mem = (cur == S_WB);
  assign pc_src      = (cur == S_JUMP) ? 2'b10 : (cur == S_BR) ? 2'b01 : 2'b00;
  assign alu_ctl     = (cur == S_EXE) ? 2'b10 : (cur == S_BR) ? 2'b01 : 2'b00;
  assign alu_b_sel   = (cur == S_FETCH) ? 2'b01 :
                       (cur == S_DEC)   ? 2'b11 :
                       (cur == S_ADDR)  ? 2'b10 : 2'b00;
  assign alu_a_sel   = (cur == S_ADDR) || (cur == S_EXE) || (cur == S_BR);
  assign reg_wr      = (cur == S_WB) || (cur == S_RDONE);
  assign dst_sel     = (cur == S_RDONE);

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> (alu_b_sel == 2'b11 && !ir_ld));

  // R3
  unknown_op_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_DEC && opcode != OP_ALU && opcode != OP_LOAD && opcode != OP_STORE &&
     opcode != OP_BEQ && opcode != OP_JUMP) |=> ir_ld);

  // R5
  load_read_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel) |=> (reg_wr && wb_from_mem));

  // R6 R8
  regwrite_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ir_ld);

  // R7
  store_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_ld);

  // R9
  branch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_ld);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'b111111;
  logic pc_wr_en, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_from_mem;
  logic [1:0] pc_src, alu_ctl, alu_b_sel;
  logic alu_a_sel, reg_wr, dst_sel;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm u0 (.clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .wb_from_mem(wb_from_mem),
    .pc_src(pc_src), .alu_ctl(alu_ctl), .alu_b_sel(alu_b_sel),
    .alu_a_sel(alu_a_sel), .reg_wr(reg_wr), .dst_sel(dst_sel));

  // word: [15]pc_wr_en [14]pc_wr_cond [13]addr_sel [12]mem_rd [11]mem_wr [10]ir_ld
  //       [9]wb_from_mem [8:7]pc_src [6:5]alu_ctl [4:3]alu_b_sel [2]alu_a_sel [1]reg_wr [0]dst_sel
  localparam logic [15:0] W_FETCH = 16'h9408, W_DEC = 16'h0018, W_ADDR = 16'h0014,
    W_RD = 16'h3000, W_WB = 16'h0202, W_WR = 16'h2800, W_EXE = 16'h0044,
    W_RC = 16'h0003, W_BR = 16'h40A4, W_JMP = 16'h8100;

  wire [15:0] word = {pc_wr_en, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_from_mem,
                      pc_src, alu_ctl, alu_b_sel, alu_a_sel, reg_wr, dst_sel};

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [15:0] w, string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // called just after the edge that entered fetch
  task automatic issue(logic [5:0] op);
    int n;
    opcode = op;
    push(W_FETCH, "R1"); push(W_DEC, "R2");
    case (op)
      6'b100011: begin push(W_ADDR, "R4"); push(W_RD, "R5"); push(W_WB, "R6"); end
      6'b101011: begin push(W_ADDR, "R4"); push(W_WR, "R7"); end
      6'b000000: begin push(W_EXE, "R8"); push(W_RC, "R8"); end
      6'b000100: push(W_BR, "R9");
      6'b000010: push(W_JMP, "R10");
      default: ;
    endcase
    n = exp_q.size();
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, word, e);
      if (mem_rd && mem_wr) check("R11", 16'h0001, 16'h0000);
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", word, W_FETCH);
    @(posedge clk); #1;
    rst_n = 1'b1;
    issue(6'b100011);
    issue(6'b101011);
    issue(6'b000000);
    issue(6'b000100);
    issue(6'b000010);
    issue(6'b111111);
    issue(6'b000000);
    issue(6'b100011);
    issue(6'b001000);
    issue(6'b101011);
    issue(6'b000010);
    @(negedge clk);
    check("R3 queue drained", 16'(exp_q.size()), 16'h0000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule